// File: doc/BRIEF.md
# Registered Address Window Decoder

This block maps a 16-bit bus address onto eight chip-select lines. The address arrives as a high byte and a low byte, together with an address strobe. Each select line covers one fixed window near the top of the map. The windows are uneven in size: the smallest is a single address at 0xE2AB, and the largest is the 4 KiB block at 0xF000. When a strobed address falls below every window, the block raises a bus-error flag instead of a select.

Both outputs are registered on the rising clock edge, so a new address appears on the outputs one cycle after it is presented. While the strobe is low, every select line is off and the bus-error flag keeps its last value. Software or a bus monitor can therefore still read the error after the strobe has been released.

The window bases are one packed parameter vector. Base k is the lowest address of select k. Window k runs from base k up to one below base k-1. Window 0 runs from its base up to the top of the address space. A synchronous reset, active high, clears both outputs.

Top module: `addr_window_decoder`

## Requirements
- R1: With the strobe high, an address from 0xF000 to 0xFFFF sets select bit 0 only (select value 0x01) and clears the bus-error flag.
- R2: With the strobe high, the windows 0xE800–0xEFFF, 0xE400–0xE7FF and 0xE300–0xE3FF set only select bit 1, bit 2 and bit 3 (0x02, 0x04, 0x08).
- R3: With the strobe high, the windows 0xE2C0–0xE2FF, 0xE2B0–0xE2BF and 0xE2AC–0xE2AF, and the single address 0xE2AB, set only select bit 4, bit 5, bit 6 and bit 7 (0x10, 0x20, 0x40, 0x80).
- R4: With the strobe high, any address below 0xE2AB drives the select to 0x00 and sets the bus-error flag to 1.
- R5: With the strobe high, an address inside any window clears the bus-error flag to 0.
- R6: With the strobe low, the select becomes 0x00 and the bus-error flag keeps its previous value, whatever the address.
- R7: Reset is synchronous and active high. It overrides the strobe and leaves the select at 0x00 and the bus-error flag at 0 after the edge.
- R8: Outputs change only at a rising clock edge, and they reflect the inputs sampled at that edge. This gives one cycle of latency.
- R9: At most one select bit is high at a time, and no select bit is high in a cycle where the bus-error flag is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| addr_strobe | input | 1 | The address is valid when this is high |
| addr_lo | input | 8 | Address bits 7..0 |
| addr_hi | input | 8 | Address bits 15..8 |
| bus_err | output | 1 | Registered flag: a strobed address fell below every window |
| sel | output | 8 | Registered one-hot window select; bit k belongs to window k |

## Verification
The bench builds the block with its default parameters: a 16-bit address split into two bytes, and the eight default window bases. With these values every window edge is a concrete address that can be driven directly. The bench checks the first and last address of each window, plus the address just below the lowest window, against a separate range model. The hold of the bus-error flag is checked with the strobe low after both a failing and a passing access. The reset-over-strobe case and the one-cycle latency are also covered.

// File: rtl/addr_dec_pkg.sv
package addr_dec_pkg;

   localparam int unsigned DEF_BYTE_W = 8;
   localparam int unsigned DEF_ADDR_W = 2 * DEF_BYTE_W;
   localparam int unsigned DEF_N_WIN  = 8;

   // Base of window k sits in slice [k*ADDR_W +: ADDR_W]; bases descend with k.
   localparam logic [DEF_N_WIN*DEF_ADDR_W-1:0] DEF_WIN_BASES = {
      16'hE2AB, 16'hE2AC, 16'hE2B0, 16'hE2C0,
      16'hE300, 16'hE400, 16'hE800, 16'hF000
   };

endpackage

// File: rtl/win_cmp.sv
module win_cmp #(
   parameter int unsigned                     ADDR_W    = 16,
   parameter int unsigned                     N_WIN     = 8,
   parameter logic [N_WIN*ADDR_W-1:0]         WIN_BASES = '0
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [N_WIN-1:0]  at_or_above
);

   for (genvar k = 0; k < N_WIN; k++) begin : g_cmp
      localparam logic [ADDR_W-1:0] BASE_K = WIN_BASES[k*ADDR_W +: ADDR_W];
      assign at_or_above[k] = (addr >= BASE_K);
   end

endmodule

// File: rtl/win_sel.sv
module win_sel #(
   parameter int unsigned N_WIN = 8
) (
   input  logic [N_WIN-1:0] at_or_above,
   output logic [N_WIN-1:0] hit,
   output logic             below_all
);

   // Window 0 is open at the top; every lower window stops below its neighbour's base.
   assign hit[0] = at_or_above[0];

   for (genvar k = 1; k < N_WIN; k++) begin : g_edge
      assign hit[k] = at_or_above[k] & ~at_or_above[k-1];
   end

   assign below_all = ~at_or_above[N_WIN-1];

endmodule

// File: rtl/dec_reg.sv
module dec_reg #(
   parameter int unsigned N_WIN = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             strobe,
   input  logic [N_WIN-1:0] hit,
   input  logic             below_all,
   output logic [N_WIN-1:0] sel_q,
   output logic             berr_q
);

   always_ff @(posedge clk) begin
      if (rst) begin
         sel_q  <= '0;
         berr_q <= 1'b0;
      end else if (strobe) begin
         sel_q  <= below_all ? '0 : hit;
         berr_q <= below_all;
      end else begin
         sel_q  <= '0;
      end
   end

   // R9
   sel_onehot_chk: assert property (@(posedge clk) disable iff (rst)
      $onehot0(sel_q));

   // R9
   sel_berr_excl_chk: assert property (@(posedge clk) disable iff (rst)
      berr_q |-> (sel_q == '0));

   // R6
   idle_sel_clr_chk: assert property (@(posedge clk) disable iff (rst)
      !strobe |=> (sel_q == '0));

   // R6
   idle_berr_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !strobe |=> $stable(berr_q));

   // R4
   below_berr_chk: assert property (@(posedge clk) disable iff (rst)
      (strobe && below_all) |=> berr_q);

   // R5
   inside_berr_clr_chk: assert property (@(posedge clk) disable iff (rst)
      (strobe && (hit != '0)) |=> !berr_q);

   // R7
   reset_clear_chk: assert property (@(posedge clk)
      rst |=> ((sel_q == '0) && !berr_q));

endmodule

// File: rtl/addr_window_decoder.sv
module addr_window_decoder
   import addr_dec_pkg::*;
#(
   parameter int unsigned                 BYTE_W    = DEF_BYTE_W,
   parameter int unsigned                 N_WIN     = DEF_N_WIN,
   parameter int unsigned                 ADDR_W    = 2 * BYTE_W,
   parameter logic [N_WIN*ADDR_W-1:0]     WIN_BASES = DEF_WIN_BASES
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              addr_strobe,
   input  logic [BYTE_W-1:0] addr_lo,
   input  logic [BYTE_W-1:0] addr_hi,
   output logic              bus_err,
   output logic [N_WIN-1:0]  sel
);

   // Elaboration-time parameter checks
   if (ADDR_W != 2 * BYTE_W) begin : g_bad_width
      $error("address width must be two bytes wide");
   end
   if (N_WIN < 1) begin : g_bad_count
      $error("at least one window is required");
   end
   for (genvar k = 1; k < N_WIN; k++) begin : g_base_order
      if (WIN_BASES[k*ADDR_W +: ADDR_W] >= WIN_BASES[(k-1)*ADDR_W +: ADDR_W]) begin : g_bad_order
         $error("window bases must strictly descend with index");
      end
   end

   logic [ADDR_W-1:0] addr;
   logic [N_WIN-1:0]  ge;
   logic [N_WIN-1:0]  hit;
   logic              below_all;

   assign addr = {addr_hi, addr_lo};

   win_cmp #(
      .ADDR_W    (ADDR_W),
      .N_WIN     (N_WIN),
      .WIN_BASES (WIN_BASES)
   ) i_cmp (
      .addr        (addr),
      .at_or_above (ge)
   );

   win_sel #(
      .N_WIN (N_WIN)
   ) i_sel (
      .at_or_above (ge),
      .hit         (hit),
      .below_all   (below_all)
   );

   dec_reg #(
      .N_WIN (N_WIN)
   ) i_reg (
      .clk       (clk),
      .rst       (rst),
      .strobe    (addr_strobe),
      .hit       (hit),
      .below_all (below_all),
      .sel_q     (sel),
      .berr_q    (bus_err)
   );

endmodule

// File: tb/test_addr_window_decoder.sv
module test_addr_window_decoder;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       addr_strobe = 1'b0;
   logic [7:0] addr_lo = 8'h00;
   logic [7:0] addr_hi = 8'h00;
   logic       bus_err;
   logic [7:0] sel;

   int checks = 0;
   int fails  = 0;

   always #2.5 clk = ~clk;

   addr_window_decoder i_addr_window_decoder (
      .clk         (clk),
      .rst         (rst),
      .addr_strobe (addr_strobe),
      .addr_lo     (addr_lo),
      .addr_hi     (addr_hi),
      .bus_err     (bus_err),
      .sel         (sel)
   );

   // Range model written from the requirements.
   function automatic logic [7:0] ref_sel(input logic [15:0] a);
      if (a >= 16'hF000)                         return 8'h01;
      else if (a >= 16'hE800 && a <= 16'hEFFF)   return 8'h02;
      else if (a >= 16'hE400 && a <= 16'hE7FF)   return 8'h04;
      else if (a >= 16'hE300 && a <= 16'hE3FF)   return 8'h08;
      else if (a >= 16'hE2C0 && a <= 16'hE2FF)   return 8'h10;
      else if (a >= 16'hE2B0 && a <= 16'hE2BF)   return 8'h20;
      else if (a >= 16'hE2AC && a <= 16'hE2AF)   return 8'h40;
      else if (a == 16'hE2AB)                    return 8'h80;
      else                                       return 8'h00;
   endfunction

   function automatic string tag(input int r);
      case (r)
         1: return "R1";
         2: return "R2";
         3: return "R3";
         4: return "R4";
         5: return "R5";
         6: return "R6";
         7: return "R7";
         8: return "R8";
         default: return "R9";
      endcase
   endfunction

   task automatic check(input string req, input logic eb, input logic [7:0] es);
      checks++;
      if (bus_err !== eb || sel !== es) begin
         fails++;
         $display("FAIL %s: actual bus_err=%b sel=%02h expected bus_err=%b sel=%02h",
                  req, bus_err, sel, eb, es);
      end
      // R9
      checks++;
      if (!$onehot0(sel) || (bus_err && sel != 8'h00)) begin
         fails++;
         $display("FAIL R9: actual bus_err=%b sel=%02h expected at most one of them",
                  bus_err, sel);
      end
   endtask

   task automatic drive(input logic r, input logic s, input logic [15:0] a);
      rst = r; addr_strobe = s; {addr_hi, addr_lo} = a;
      @(posedge clk);
      #1;
   endtask

   // {req[3:0], rst, strobe, addr[15:0], berr, sel[7:0]}
   localparam int NV = 18;
   localparam logic [30:0] VEC [NV] = '{
      {4'd7, 1'b1, 1'b1, 16'hE2AB, 1'b0, 8'h00},
      {4'd4, 1'b0, 1'b1, 16'h0000, 1'b1, 8'h00},
      {4'd4, 1'b0, 1'b1, 16'h00A0, 1'b1, 8'h00},
      {4'd4, 1'b0, 1'b1, 16'hE2AA, 1'b1, 8'h00},
      {4'd5, 1'b0, 1'b1, 16'hE2AB, 1'b0, 8'h80},
      {4'd3, 1'b0, 1'b1, 16'hE2AC, 1'b0, 8'h40},
      {4'd3, 1'b0, 1'b1, 16'hE2B0, 1'b0, 8'h20},
      {4'd3, 1'b0, 1'b1, 16'hE2C0, 1'b0, 8'h10},
      {4'd2, 1'b0, 1'b1, 16'hE300, 1'b0, 8'h08},
      {4'd2, 1'b0, 1'b1, 16'hE400, 1'b0, 8'h04},
      {4'd2, 1'b0, 1'b1, 16'hE800, 1'b0, 8'h02},
      {4'd1, 1'b0, 1'b1, 16'hF000, 1'b0, 8'h01},
      {4'd6, 1'b0, 1'b0, 16'hFFFF, 1'b0, 8'h00},
      {4'd4, 1'b0, 1'b1, 16'h0002, 1'b1, 8'h00},
      {4'd6, 1'b0, 1'b0, 16'hF000, 1'b1, 8'h00},
      {4'd6, 1'b0, 1'b0, 16'h0000, 1'b1, 8'h00},
      {4'd1, 1'b0, 1'b1, 16'hFFFF, 1'b0, 8'h01},
      {4'd7, 1'b1, 1'b0, 16'h0000, 1'b0, 8'h00}
   };

   localparam logic [15:0] LO [8] = '{16'hF000, 16'hE800, 16'hE400, 16'hE300,
                                      16'hE2C0, 16'hE2B0, 16'hE2AC, 16'hE2AB};
   localparam logic [15:0] HI [8] = '{16'hFFFF, 16'hEFFF, 16'hE7FF, 16'hE3FF,
                                      16'hE2FF, 16'hE2BF, 16'hE2AF, 16'hE2AB};

   initial begin : watchdog
      repeat (5000) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL R8: actual run still going expected finished before watchdog");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin : stim
      logic [7:0] es;
      #1;
      drive(1'b1, 1'b0, 16'h0000);
      check("R7", 1'b0, 8'h00);

      for (int i = 0; i < NV; i++) begin
         drive(VEC[i][26], VEC[i][25], VEC[i][24:9]);
         check(tag(int'(VEC[i][30:27])), VEC[i][8], VEC[i][7:0]);
      end

      // Window edges against the range model: R1 (k=0), R2 (k=1..3), R3 (k=4..7)
      for (int k = 0; k < 8; k++) begin
         string r;
         r = (k == 0) ? "R1" : (k < 4) ? "R2" : "R3";
         es = ref_sel(LO[k]);
         drive(1'b0, 1'b1, LO[k]);
         check(r, es == 8'h00, es);
         es = ref_sel(HI[k]);
         drive(1'b0, 1'b1, HI[k]);
         check(r, es == 8'h00, es);
      end
      drive(1'b0, 1'b1, 16'hE2AA);
      check("R4", 1'b1, ref_sel(16'hE2AA));

      // R6: hold error through several idle cycles with addresses moving
      drive(1'b0, 1'b0, 16'hE2AB);
      check("R6", 1'b1, 8'h00);
      drive(1'b0, 1'b0, 16'hF123);
      check("R6", 1'b1, 8'h00);

      // R5: valid access clears the held error
      drive(1'b0, 1'b1, 16'hE555);
      check("R5", 1'b0, 8'h04);

      // R8: change inputs away from the edge; outputs wait for the next edge
      rst = 1'b0; addr_strobe = 1'b1; {addr_hi, addr_lo} = 16'h0001;
      #1;
      check("R8", 1'b0, 8'h04);
      @(posedge clk);
      #1;
      check("R8", 1'b1, 8'h00);

      // R7: reset beats a strobed error address and clears the held flag
      drive(1'b1, 1'b1, 16'h0001);
      check("R7", 1'b0, 8'h00);
      drive(1'b0, 1'b0, 16'h0001);
      check("R7", 1'b0, 8'h00);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule